// File: doc/BRIEF.md
# Weighted-Pad Pixel Array with Code Replication

This block is a small array of binary pixels. Each pixel drives eight on/off modulation pads whose areas are weighted by powers of two, 128 down to 1. When all pads of a pixel are averaged, the lit area stands for an 8-bit intensity. A host writes a short code to one pixel at a time. The code has a length L between 1 and 8 bits. The block turns that code into eight pad states without any arithmetic. The heaviest L pads take the code bits, most significant bit first. The pads below them take the same bits again, starting over from the most significant bit, until all eight pads have a value.

Each pixel keeps its pad states in its own register until that pixel is written again. All pad states of the whole array are presented at once on a single wide output bus.

Top module: `mpad_pixel_array`

## Requirements
- R1: A synchronous active-low reset clears every pad of every pixel to 0 on the clock edge where `rst_n` is low. Reset takes priority over a write presented on the same edge.
- R2: When `wr_en` is high on a rising edge and the length is valid, the pixel with index `wr_row*4 + wr_col` takes its new pad states. They appear on `pad_states[8*idx +: 8]` right after that edge. Bit b of the byte drives the pad of weight 2^b.
- R3: A write changes no pixel other than the addressed one.
- R4: While `wr_en` is low, no pad state changes.
- R5: A write whose `wr_len` is 0 or greater than 8 is ignored. All pad states stay as they were.
- R6: For a valid length L, the pad of weight 2^b takes the code bit at index L-1-((7-b) mod L).
- R7: Code bits at index L or above have no effect on the stored pads.
- R8: With L=2, the code LSB drives the pads of weight 64, 16, 4 and 1. Code 01 gives 0x55 and code 10 gives 0xAA.
- R9: With L=5, the code LSB drives only the pad of weight 8, so code 00001 gives 0x08. Code bit 2 drives the pads of weight 32 and 1, so code 00100 gives 0x21.
- R10: For L of 1, 2, 4 or 8, the pad sum equals code*255/(2^L-1) exactly. For any valid L, a code of all ones lights all eight pads (0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_row | input | 2 | Row of the pixel to write |
| wr_col | input | 2 | Column of the pixel to write |
| wr_code | input | 8 | Compressed code, right-aligned; only the low `wr_len` bits are used |
| wr_len | input | 4 | Code length L; valid range 1 to 8 |
| pad_states | output | 128 | Pad states of all 16 pixels, 8 bits per pixel, pixel index `row*4+col` |

## Verification
A fault in the expansion network shows at once: one pad of the written pixel is wrong, and the pattern of wrong pads points to the length case that was mis-wired. A fault in the address decode or the load gating shows up differently. It corrupts a pixel that was not addressed, and it appears one cycle after the write as a change on a byte that should have stayed put. Because of this, every write is followed by a comparison of all 128 pad bits against a bench model. This catches such side effects on the first write that triggers them, not only when the damaged pixel is next read.

// File: rtl/mpad_pkg.sv
// Package: shared sizes and the pad-to-code-bit mapping rule.
// Assumes pad index b has weight 2**b and codes are right-aligned.
package mpad_pkg;

    localparam int PAD_COUNT = 8;

    // Code bit index that drives pad b for code length len (len >= 1).
    // Pads are visited from heaviest to lightest, cycling MSB-first.
    function automatic int src_bit(input int len, input int b);
        return len - 1 - ((PAD_COUNT - 1 - b) % len);
    endfunction

endpackage

// File: rtl/mpad_addr_decoder.sv
// Address decoder: turns a row/column pair and an enable into a one-hot
// pixel select. Assumes pixels are numbered row*COLS+col. An address
// outside the array selects nothing.
module mpad_addr_decoder #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int ROW_W = 2,
    parameter int COL_W = 2
) (
    input  logic                   en,
    input  logic [ROW_W-1:0]       row,
    input  logic [COL_W-1:0]       col,
    output logic [ROWS*COLS-1:0]   sel
);

    localparam int PIXELS = ROWS * COLS;

    // One select line per pixel, matched against the incoming address.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign sel[r*COLS + c] = en && (int'(row) == r) && (int'(col) == c);
        end
    end

    // Guard: at most one pixel is ever selected.
    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(sel) || $isunknown(sel)); // R3
    end

endmodule

// File: rtl/mpad_expander.sv
// Code expander: maps a right-aligned code of length len onto PADS
// binary pads by cyclic MSB-first replication. Assumes len is checked
// here; len_ok flags lengths 1..PADS. The output is zero otherwise.
module mpad_expander #(
    parameter int PADS  = mpad_pkg::PAD_COUNT,
    parameter int LEN_W = 4
) (
    input  logic [PADS-1:0]  code,
    input  logic [LEN_W-1:0] len,
    output logic [PADS-1:0]  pads,
    output logic             len_ok
);

    // One fixed wiring pattern per legal length.
    logic [PADS-1:0] cand [1:PADS];

    for (genvar gl = 1; gl <= PADS; gl++) begin : g_len
        for (genvar gb = 0; gb < PADS; gb++) begin : g_pad
            assign cand[gl][gb] = code[mpad_pkg::src_bit(gl, gb)];
        end
    end

    // Length range check.
    assign len_ok = (len != '0) && (int'(len) <= PADS);

    // Pick the wiring pattern that matches the requested length.
    always_comb begin
        pads = '0;
        for (int l = 1; l <= PADS; l++) begin
            if (int'(len) == l) pads = cand[l];
        end
    end

endmodule

// File: rtl/mpad_pixel.sv
// Pixel cell: holds the pad states of one pixel. Loads pad_in when load
// is high, clears on synchronous active-low reset, and holds otherwise.
module mpad_pixel #(
    parameter int PADS = mpad_pkg::PAD_COUNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PADS-1:0] pad_in,
    output logic [PADS-1:0] pads
);

    // Pad state register with reset priority over load.
    always_ff @(posedge clk) begin
        if (!rst_n)    pads <= '0;
        else if (load) pads <= pad_in;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pads == $past(pad_in)); // R2

    AST_HOLD_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pads)); // R3

endmodule

// File: rtl/mpad_pixel_array.sv
// Pixel array top: decodes the write address, expands the code onto
// the pads and stores the result in the selected pixel. Assumes one
// write per cycle at most; all pixels are presented in parallel.
module mpad_pixel_array #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int PADS  = mpad_pkg::PAD_COUNT,
    parameter int ROW_W = 2,
    parameter int COL_W = 2,
    parameter int LEN_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ROW_W-1:0]          wr_row,
    input  logic [COL_W-1:0]          wr_col,
    input  logic [PADS-1:0]           wr_code,
    input  logic [LEN_W-1:0]          wr_len,
    output logic [ROWS*COLS*PADS-1:0] pad_states
);

    localparam int PIXELS = ROWS * COLS;

    logic [PADS-1:0]   expanded;
    logic              len_ok;
    logic              wr_ok;
    logic [PIXELS-1:0] sel;
    logic [PADS-1:0]   len_mask;

    mpad_expander #(.PADS(PADS), .LEN_W(LEN_W)) u_expander (
        .code   (wr_code),
        .len    (wr_len),
        .pads   (expanded),
        .len_ok (len_ok)
    );

    // A write only counts when the length is legal.
    assign wr_ok = wr_en && len_ok;

    mpad_addr_decoder #(
        .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_decoder (
        .en  (wr_ok),
        .row (wr_row),
        .col (wr_col),
        .sel (sel)
    );

    // One storage cell per pixel, packed onto the output bus.
    for (genvar p = 0; p < PIXELS; p++) begin : g_pix
        mpad_pixel #(.PADS(PADS)) u_pixel (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (sel[p]),
            .pad_in (expanded),
            .pads   (pad_states[p*PADS +: PADS])
        );
    end

    // Mask of the code bits in use; only feeds an assertion.
    always_comb begin
        len_mask = '0;
        for (int i = 0; i < PADS; i++) begin
            if (i < int'(wr_len)) len_mask[i] = 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> pad_states == '0); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pad_states)); // R4

    AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !len_ok) |=> $stable(pad_states)); // R5

    AST_FULL_CODE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && len_ok && ((wr_code & len_mask) == len_mask))
            |-> expanded == '1); // R10

endmodule

// File: tb/mpad_pixel_array_test.sv
module mpad_pixel_array_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_row = '0;
    logic [1:0]   wr_col = '0;
    logic [7:0]   wr_code = '0;
    logic [3:0]   wr_len = '0;
    logic [127:0] pad_states;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] model [16];

    always #5 clk = ~clk;

    mpad_pixel_array uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_col(wr_col), .wr_code(wr_code), .wr_len(wr_len),
        .pad_states(pad_states)
    );

    // Reference expansion written from the mapping rule.
    function automatic logic [7:0] expand(input logic [7:0] code, input int len);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = code[len - 1 - ((7 - b) % len)];
        return r;
    endfunction

    function automatic logic [127:0] model_vec();
        logic [127:0] v;
        for (int p = 0; p < 16; p++) v[p*8 +: 8] = model[p];
        return v;
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (pad_states !== model_vec()) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, pad_states, model_vec());
        end
    endtask

    task automatic check_pix(input string tag, input int p, input logic [7:0] exp);
        checks++;
        if (pad_states[p*8 +: 8] !== exp) begin
            errors++;
            $display("FAIL %s: pixel %0d actual=%h expected=%h",
                     tag, p, pad_states[p*8 +: 8], exp);
        end
    endtask

    // Drive one operation, let one edge pass, update the model, compare.
    task automatic op(input logic en, input int row, input int col,
                      input logic [7:0] code, input int len, input string tag);
        @(negedge clk);
        wr_en = en; wr_row = 2'(row); wr_col = 2'(col);
        wr_code = code; wr_len = 4'(len);
        @(negedge clk);
        if (en && len >= 1 && len <= 8) model[row*4 + col] = expand(code, len);
        check_all(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        for (int p = 0; p < 16; p++) model[p] = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 reset state");
        rst_n = 1'b1;

        op(1, 1, 2, 8'h01, 2, "R8 L2 code01");
        check_pix("R8 L2 code01 value", 6, 8'h55);
        op(1, 1, 2, 8'h02, 2, "R8 L2 code10");
        check_pix("R8 L2 code10 value", 6, 8'hAA);
        op(1, 3, 3, 8'h01, 5, "R9 L5 lsb");
        check_pix("R9 L5 lsb value", 15, 8'h08);
        op(1, 0, 0, 8'h04, 5, "R6 R9 L5 bit2");
        check_pix("R9 L5 bit2 value", 0, 8'h21);
        op(1, 0, 1, 8'h01, 1, "R10 L1");
        check_pix("R10 L1 value", 1, 8'hFF);
        op(1, 0, 2, 8'h05, 4, "R10 L4");
        check_pix("R10 L4 value", 2, 8'h55);
        op(1, 0, 3, 8'hA7, 8, "R10 L8");
        check_pix("R10 L8 value", 3, 8'hA7);
        op(1, 2, 1, 8'h07, 3, "R10 L3 all ones");
        check_pix("R10 L3 all ones value", 9, 8'hFF);
        op(1, 2, 2, 8'hFA, 3, "R7 high bits");
        check_pix("R7 high bits value", 10, 8'h49);
        op(1, 2, 2, 8'h33, 0, "R5 len0");
        op(1, 2, 2, 8'h33, 9, "R5 len9");
        op(1, 2, 2, 8'h33, 15, "R5 len15");
        check_pix("R5 pixel kept", 10, 8'h49);
        op(0, 2, 2, 8'h33, 4, "R4 no enable");
        op(1, 3, 0, 8'h9C, 8, "R2 R3 neighbour check");

        // Random mix of writes, idle cycles and illegal lengths.
        for (int i = 0; i < 400; i++) begin
            op(($urandom % 4) != 0, $urandom % 4, $urandom % 4,
               8'($urandom), $urandom % 11, "R2 R3 R6 random");
        end

        // Reset while a write is presented.
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_row = 2'd1; wr_col = 2'd1;
        wr_code = 8'hFF; wr_len = 4'd8;
        @(negedge clk);
        for (int p = 0; p < 16; p++) model[p] = '0;
        check_all("R1 reset over write");
        rst_n = 1'b1; wr_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule